// File: doc/BRIEF.md
# Serial command and display-data receiver

This block is the host-facing serial slave of a fluorescent-display driver. A host selects it with an active-low chip select and clocks bytes over one bidirectional data line. Both directions carry each byte least-significant bit first. The serial clock and the incoming data are oversampled by the fast system clock. A level is accepted only after two consecutive matching samples, so short glitches are rejected.

Each transaction opens with five output byte slots. The block first sends a filler byte, then the four converter result bytes presented on a parallel input. From the sixth slot the line turns into an input. The first input byte is a command whose top three bits select one of four actions: display data, display state, number of timing slots, or port data. After a display-data command, every following byte until chip select rises goes to a display RAM write port. Addresses are generated automatically, walking the timing slots from the highest down to the first.

Top module: `fld_serial_rx`

## Requirements
- R1: While cs_n has been high for three or more clocks, sdata_oe is 0.
- R2: sclk and sdata_in change their internal level only after two consecutive equal synchronized samples. A high pulse on sclk lasting one clock is ignored.
- R3: Every byte moves bit 0 first and bit 7 last. The host drives sdata_in before the rising sclk edge, and the block samples it on that edge. sdata_out changes after falling edges.
- R4: In slots 1 to 5 of a frame, sdata_oe is 1. The block sends 0xFF, then adc_data[7:0], [15:8], [23:16] and [31:24]. From slot 6 sdata_oe is 0, and the line carries input bytes.
- R5: A first input byte with bits 7..5 = 111 is the display-data command. Bit 4 drives three_byte (1 = three bytes per slot), and bits 3..0 drive start_code.
- R6: A first input byte with bits 7..5 = 110 is the display-state command. Bit 0 drives disp_on, bits 2..1 drive duty_sel, and bits 4..3 are held as a pending pin mode.
- R7: pin_mode takes the pending mode only when a port command (bits 7..5 = 100) is accepted.
- R8: A first input byte with bits 7..5 = 101 carries a code in bits 3..0. Codes 0 to 11 set slot_count to 16 minus the code. Codes 12 to 15 leave it unchanged.
- R9: A port command copies bits 2..0 to port_out.
- R10: Bytes after a display-data command produce one ram_we pulse each, at address slot*4 + index. Writing starts at slot slot_count-1 with index 0. The index wraps after 3 or 4 bytes, the slot then counts down, and after slot 0 it wraps back to slot_count-1.
- R11: A chip-select rise in mid-byte discards the partial byte. The next frame starts again at slot 1.
- R12: After a command other than display data, further bytes in the same frame are ignored.
- R13: After reset: disp_on=0, duty_sel=0, pin_mode=3, port_out=0, slot_count=16, three_byte=0, start_code=0, sdata_oe=0, no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from host, idle low |
| sdata_in | input | 1 | Data line as seen from the pad |
| sdata_out | output | 1 | Data driven toward the pad |
| sdata_oe | output | 1 | Output enable for the data pad |
| adc_data | input | 32 | Four converter bytes, channel 0 in the low byte |
| disp_on | output | 1 | Display enabled |
| duty_sel | output | 2 | Dimming duty code |
| pin_mode | output | 2 | Active digit/port pin mode |
| port_out | output | 3 | General output port bits |
| slot_count | output | 5 | Number of timing slots (5 to 16) |
| three_byte | output | 1 | Three bytes per slot when 1, four when 0 |
| start_code | output | 4 | Digit start pin code |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | 6 | Display RAM write address |
| ram_wdata | output | 8 | Display RAM write data |

## Verification
The bench checks that the output shifter is reloaded at the last falling edge of each byte. A design that reloads one edge late would return converter bytes shifted by one bit. It checks the address walk in both bytes-per-slot modes, including the wrap from slot 0 back to the top slot; an off-by-one there writes the wrong RAM word or index 3 in three-byte mode. It aborts a frame mid-byte to catch a bit counter that survives chip select, which would misalign every later frame. It injects a one-clock sclk glitch, which an unfiltered design would count as an extra bit. It also checks that the pending pin mode stays invisible until a port command, and that bytes after a non-display command are ignored.

// File: rtl/fld_rx_pkg.sv
package fld_rx_pkg;
  localparam int BYTE_W    = 8;
  localparam int MIN_SLOTS = 5;

  typedef enum logic [2:0] {
    OP_PORT   = 3'b100,
    OP_TIMING = 3'b101,
    OP_STATE  = 3'b110,
    OP_DISP   = 3'b111
  } opcode_e;
endpackage

// File: rtl/fld_pin_filter.sv
// Synchronizer plus optional majority-free run filter on one input pin.
module fld_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2,
  parameter bit RESET_VAL   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_STAGES{RESET_VAL}};
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end

  generate
    if (FILT_LEN >= 2) begin : g_filt
      logic [FILT_LEN-1:0] hist_q;
      logic                lvl_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          hist_q <= {FILT_LEN{RESET_VAL}};
          lvl_q  <= RESET_VAL;
        end else begin
          hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
          if (&hist_q)       lvl_q <= 1'b1;
          else if (~|hist_q) lvl_q <= 1'b0;
        end
      end
      assign level = lvl_q;
    end else begin : g_bypass
      assign level = sync_q[SYNC_STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/fld_byte_link.sv
// Frame engine: bit/byte counting, output slots, input byte delivery.
module fld_byte_link
  import fld_rx_pkg::*;
#(
  parameter int          ADC_CH    = 4,
  parameter logic [7:0]  IDLE_BYTE = 8'hFF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_act,
  input  logic                     sclk_f,
  input  logic                     sdata_f,
  input  logic [ADC_CH*BYTE_W-1:0] adc_bytes,
  output logic                     sdo,
  output logic                     sdo_en,
  output logic                     rx_valid,
  output logic                     rx_first,
  output logic [BYTE_W-1:0]        rx_byte
);
  localparam int OUT_SLOTS = ADC_CH + 1;
  localparam int SLOT_W    = $clog2(OUT_SLOTS + 1);
  localparam int BIT_W     = $clog2(BYTE_W);
  localparam int CH_W      = (ADC_CH > 1) ? $clog2(ADC_CH) : 1;
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [SLOT_W-1:0] IN_SLOT  = SLOT_W'(OUT_SLOTS);

  logic [BYTE_W-1:0] adc_arr [ADC_CH];
  for (genvar c = 0; c < ADC_CH; c++) begin : g_adc
    assign adc_arr[c] = adc_bytes[c*BYTE_W +: BYTE_W];
  end

  logic              sclk_d, cs_d, seen_in;
  logic [BIT_W-1:0]  bit_cnt;
  logic [SLOT_W-1:0] slot;
  logic [BYTE_W-1:0] tx_sr, rx_sr;
  logic [CH_W-1:0]   ch_idx;

  wire sclk_rise = sclk_f & ~sclk_d;
  wire sclk_fall = ~sclk_f & sclk_d;
  assign ch_idx  = CH_W'(slot - 1'b1);
  assign sdo     = tx_sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      cs_d     <= 1'b0;
      seen_in  <= 1'b0;
      bit_cnt  <= '0;
      slot     <= '0;
      tx_sr    <= IDLE_BYTE;
      rx_sr    <= '0;
      sdo_en   <= 1'b0;
      rx_valid <= 1'b0;
      rx_first <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      sclk_d   <= sclk_f;
      cs_d     <= cs_act;
      if (!cs_act) begin
        bit_cnt <= '0;
        slot    <= '0;
        seen_in <= 1'b0;
        sdo_en  <= 1'b0;
      end else if (!cs_d) begin
        bit_cnt <= '0;
        slot    <= '0;
        tx_sr   <= IDLE_BYTE;
        sdo_en  <= 1'b1;
      end else begin
        if (sclk_rise) begin
          rx_sr <= {sdata_f, rx_sr[BYTE_W-1:1]};
          if (bit_cnt == LAST_BIT) begin
            bit_cnt <= '0;
            if (slot == IN_SLOT) begin
              rx_valid <= 1'b1;
              rx_byte  <= {sdata_f, rx_sr[BYTE_W-1:1]};
              rx_first <= !seen_in;
              seen_in  <= 1'b1;
            end else begin
              slot <= slot + 1'b1;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (sclk_fall) begin
          if (bit_cnt == '0 && slot != '0) begin
            if (slot < IN_SLOT) tx_sr  <= adc_arr[ch_idx];
            else                sdo_en <= 1'b0;
          end else begin
            tx_sr <= {1'b1, tx_sr[BYTE_W-1:1]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/fld_cmd_decode.sv
// Command decoder, configuration registers and display RAM address walk.
module fld_cmd_decode
  import fld_rx_pkg::*;
#(
  parameter int MAX_SLOTS = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cs_act,
  input  logic                           rx_valid,
  input  logic                           rx_first,
  input  logic [BYTE_W-1:0]              rx_byte,
  output logic                           disp_on,
  output logic [1:0]                     duty_sel,
  output logic [1:0]                     pin_mode,
  output logic [2:0]                     port_out,
  output logic [$clog2(MAX_SLOTS+1)-1:0] slot_count,
  output logic                           three_byte,
  output logic [3:0]                     start_code,
  output logic                           ram_we,
  output logic [$clog2(MAX_SLOTS)+1:0]   ram_addr,
  output logic [BYTE_W-1:0]              ram_wdata
);
  localparam int CNT_W    = $clog2(MAX_SLOTS + 1);
  localparam int SIDX_W   = $clog2(MAX_SLOTS);
  localparam int MAX_CODE = MAX_SLOTS - MIN_SLOTS;

  logic              in_data;
  logic [1:0]        pend_mode, byte_idx, last_idx;
  logic [SIDX_W-1:0] slot_idx, top_slot;

  assign last_idx = three_byte ? 2'd2 : 2'd3;
  assign top_slot = SIDX_W'(slot_count - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_data    <= 1'b0;
      pend_mode  <= 2'b11;
      pin_mode   <= 2'b11;
      disp_on    <= 1'b0;
      duty_sel   <= 2'b00;
      port_out   <= 3'b000;
      slot_count <= CNT_W'(MAX_SLOTS);
      three_byte <= 1'b0;
      start_code <= 4'h0;
      slot_idx   <= '0;
      byte_idx   <= '0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
    end else begin
      ram_we <= 1'b0;
      if (!cs_act) begin
        in_data <= 1'b0;
      end else if (rx_valid) begin
        if (rx_first) begin
          case (rx_byte[7:5])
            OP_DISP: begin
              three_byte <= rx_byte[4];
              start_code <= rx_byte[3:0];
              in_data    <= 1'b1;
              slot_idx   <= top_slot;
              byte_idx   <= 2'd0;
            end
            OP_STATE: begin
              disp_on   <= rx_byte[0];
              duty_sel  <= rx_byte[2:1];
              pend_mode <= rx_byte[4:3];
            end
            OP_TIMING: begin
              if (rx_byte[3:0] <= 4'(MAX_CODE))
                slot_count <= CNT_W'(MAX_SLOTS) - CNT_W'(rx_byte[3:0]);
            end
            OP_PORT: begin
              port_out <= rx_byte[2:0];
              pin_mode <= pend_mode;
            end
            default: ;
          endcase
        end else if (in_data) begin
          ram_we    <= 1'b1;
          ram_addr  <= {slot_idx, byte_idx};
          ram_wdata <= rx_byte;
          if (byte_idx == last_idx) begin
            byte_idx <= 2'd0;
            slot_idx <= (slot_idx == '0) ? top_slot : slot_idx - 1'b1;
          end else begin
            byte_idx <= byte_idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fld_serial_rx.sv
module fld_serial_rx
  import fld_rx_pkg::*;
#(
  parameter int         ADC_CH      = 4,
  parameter int         MAX_SLOTS   = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 2,
  parameter logic [7:0] IDLE_BYTE   = 8'hFF
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cs_n,
  input  logic                           sclk,
  input  logic                           sdata_in,
  output logic                           sdata_out,
  output logic                           sdata_oe,
  input  logic [ADC_CH*8-1:0]            adc_data,
  output logic                           disp_on,
  output logic [1:0]                     duty_sel,
  output logic [1:0]                     pin_mode,
  output logic [2:0]                     port_out,
  output logic [$clog2(MAX_SLOTS+1)-1:0] slot_count,
  output logic                           three_byte,
  output logic [3:0]                     start_code,
  output logic                           ram_we,
  output logic [$clog2(MAX_SLOTS)+1:0]   ram_addr,
  output logic [7:0]                     ram_wdata
);
  logic cs_lvl, sclk_f, sdata_f, rx_valid, rx_first;
  logic [BYTE_W-1:0] rx_byte;

  fld_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(1), .RESET_VAL(1'b1))
    u_cs (.clk(clk), .rst(rst), .pin(cs_n), .level(cs_lvl));
  fld_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .RESET_VAL(1'b0))
    u_sclk (.clk(clk), .rst(rst), .pin(sclk), .level(sclk_f));
  fld_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .RESET_VAL(1'b0))
    u_sdat (.clk(clk), .rst(rst), .pin(sdata_in), .level(sdata_f));

  fld_byte_link #(.ADC_CH(ADC_CH), .IDLE_BYTE(IDLE_BYTE)) u_link (
    .clk(clk), .rst(rst), .cs_act(~cs_lvl), .sclk_f(sclk_f), .sdata_f(sdata_f),
    .adc_bytes(adc_data), .sdo(sdata_out), .sdo_en(sdata_oe),
    .rx_valid(rx_valid), .rx_first(rx_first), .rx_byte(rx_byte)
  );

  fld_cmd_decode #(.MAX_SLOTS(MAX_SLOTS)) u_dec (
    .clk(clk), .rst(rst), .cs_act(~cs_lvl), .rx_valid(rx_valid),
    .rx_first(rx_first), .rx_byte(rx_byte), .disp_on(disp_on),
    .duty_sel(duty_sel), .pin_mode(pin_mode), .port_out(port_out),
    .slot_count(slot_count), .three_byte(three_byte), .start_code(start_code),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );
endmodule

// File: rtl/fld_serial_rx_chk.sv
module fld_serial_rx_chk #(
  parameter int MAX_SLOTS = 16
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           cs_n,
  input logic                           sdata_oe,
  input logic                           ram_we,
  input logic [1:0]                     addr_lo,
  input logic                           three_byte,
  input logic [$clog2(MAX_SLOTS+1)-1:0] slot_count
);
  localparam int CNT_W = $clog2(MAX_SLOTS + 1);

  assert_oe_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdata_oe);

  assert_no_write_in_output_R4: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && sdata_oe));

  assert_write_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);

  assert_three_byte_index_R10: assert property (@(posedge clk) disable iff (rst)
    (ram_we && three_byte) |-> (addr_lo != 2'd3));

  assert_slot_range_R8: assert property (@(posedge clk) disable iff (rst)
    (slot_count >= CNT_W'(5)) && (slot_count <= CNT_W'(MAX_SLOTS)));
endmodule

bind fld_serial_rx fld_serial_rx_chk #(.MAX_SLOTS(MAX_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sdata_oe(sdata_oe), .ram_we(ram_we),
  .addr_lo(ram_addr[1:0]), .three_byte(three_byte), .slot_count(slot_count)
);

// File: tb/tb_fld_serial_rx.sv
`timescale 1ns/1ps
module tb_fld_serial_rx;
  localparam int HALF = 10;

  logic clk = 0, rst = 1, cs_n = 1, sclk = 0, sdata_in = 0;
  logic [31:0] adc_data = 32'hD43C815A;
  logic sdata_out, sdata_oe, disp_on, three_byte, ram_we;
  logic [1:0] duty_sel, pin_mode;
  logic [2:0] port_out;
  logic [4:0] slot_count;
  logic [3:0] start_code;
  logic [5:0] ram_addr;
  logic [7:0] ram_wdata;

  fld_serial_rx dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, wr_n = 0;
  bit done = 0;
  logic [5:0] wr_addr [0:31];
  logic [7:0] wr_data [0:31];
  logic [7:0] tx_q [0:31];
  logic [7:0] rx_q [0:4];
  logic       oe_q [0:5];
  int glitch_byte = -1, glitch_bit = -1;

  always @(negedge clk) if (ram_we && wr_n < 32) begin
    wr_addr[wr_n] = ram_addr; wr_data[wr_n] = ram_wdata; wr_n++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input bit glitch, output logic [7:0] rx, output logic oe0);
    for (int i = 0; i < 8; i++) begin
      sdata_in = tx[i];
      if (glitch && i == 3) begin
        repeat (3) @(negedge clk); sclk = 1; @(negedge clk); sclk = 0;
        repeat (HALF - 4) @(negedge clk);
      end else repeat (HALF) @(negedge clk);
      rx[i] = sdata_out;
      if (i == 0) oe0 = sdata_oe;
      sclk = 1; repeat (HALF) @(negedge clk); sclk = 0;
    end
  endtask

  // n_in full input bytes, then part_bits bits of tx_q[n_in] before CS rises
  task automatic frame(input int n_in, input int part_bits);
    logic [7:0] r; logic o;
    @(negedge clk); cs_n = 0; repeat (10) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      xfer(8'h00, 1'b0, r, o); rx_q[k] = r; oe_q[k] = o;
    end
    for (int k = 0; k < n_in; k++) begin
      xfer(tx_q[k], (k == glitch_byte), r, o);
      if (k == 0) oe_q[5] = o;
    end
    for (int b = 0; b < part_bits; b++) begin
      sdata_in = tx_q[n_in][b]; repeat (HALF) @(negedge clk);
      sclk = 1; repeat (HALF) @(negedge clk); sclk = 0;
    end
    repeat (10) @(negedge clk); cs_n = 1; repeat (12) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R13 disp_on", disp_on, 0);     chk("R13 duty_sel", duty_sel, 0);
    chk("R13 pin_mode", pin_mode, 3);   chk("R13 port_out", port_out, 0);
    chk("R13 slot_count", slot_count, 16); chk("R13 three_byte", three_byte, 0);
    chk("R13 start_code", start_code, 0);  chk("R13 R1 sdata_oe", sdata_oe, 0);
    chk("R13 no write", wr_n, 0);
  endtask

  task automatic t_adc_and_state;
    tx_q[0] = 8'hD7; // state: mode 10, duty 11, on
    frame(1, 0);
    chk("R4 R3 filler", rx_q[0], 8'hFF);
    chk("R4 R3 ch0", rx_q[1], 8'h5A);  chk("R4 R3 ch1", rx_q[2], 8'h81);
    chk("R4 R3 ch2", rx_q[3], 8'h3C);  chk("R4 R3 ch3", rx_q[4], 8'hD4);
    chk("R4 oe slot1", oe_q[0], 1);    chk("R4 oe slot5", oe_q[4], 1);
    chk("R4 oe slot6", oe_q[5], 0);    chk("R1 oe after cs", sdata_oe, 0);
    chk("R6 disp_on", disp_on, 1);     chk("R6 duty", duty_sel, 3);
    chk("R7 mode held", pin_mode, 3);
  endtask

  task automatic t_port;
    tx_q[0] = 8'h85; frame(1, 0);
    chk("R9 port_out", port_out, 5);   chk("R7 mode applied", pin_mode, 2);
  endtask

  task automatic t_timing;
    tx_q[0] = 8'hA3; frame(1, 0); chk("R8 code3", slot_count, 13);
    tx_q[0] = 8'hAC; frame(1, 0); chk("R8 code12 ignored", slot_count, 13);
    tx_q[0] = 8'hAB; frame(1, 0); chk("R8 code11", slot_count, 5);
  endtask

  task automatic t_data4;
    int ea [8] = '{16, 17, 18, 19, 12, 13, 14, 15};
    wr_n = 0; tx_q[0] = 8'hE3;
    for (int k = 1; k <= 8; k++) tx_q[k] = 8'h0F + 8'(k);
    frame(9, 0);
    chk("R5 three_byte", three_byte, 0); chk("R5 start_code", start_code, 3);
    chk("R10 count4", wr_n, 8);
    for (int k = 0; k < 8; k++) begin
      chk("R10 addr4", wr_addr[k], ea[k]); chk("R10 data4", wr_data[k], 8'h10 + 8'(k));
    end
  endtask

  task automatic t_data3;
    wr_n = 0; tx_q[0] = 8'hF5;
    for (int k = 1; k <= 16; k++) tx_q[k] = 8'h40 + 8'(k);
    frame(17, 0);
    chk("R5 three_byte", three_byte, 1); chk("R5 start_code", start_code, 5);
    chk("R10 count3", wr_n, 16);
    chk("R10 first", wr_addr[0], 16);  chk("R10 idx2", wr_addr[2], 18);
    chk("R10 next slot", wr_addr[3], 12); chk("R10 slot0 last", wr_addr[14], 2);
    chk("R10 wrap", wr_addr[15], 16);  chk("R10 wrap data", wr_data[15], 8'h50);
  endtask

  task automatic t_ignore;
    wr_n = 0; tx_q[0] = 8'h81; tx_q[1] = 8'hE7; tx_q[2] = 8'h55;
    frame(3, 0);
    chk("R12 port applied", port_out, 1); chk("R12 no write", wr_n, 0);
    chk("R12 start kept", start_code, 5);
  endtask

  task automatic t_abort;
    wr_n = 0; tx_q[0] = 8'hE0; tx_q[1] = 8'h77; tx_q[2] = 8'hFF;
    frame(2, 4);
    chk("R11 one write", wr_n, 1);
    adc_data = 32'h01020304;
    tx_q[0] = 8'h82; frame(1, 0);
    chk("R11 realigned ch0", rx_q[1], 8'h04); chk("R11 realigned ch3", rx_q[4], 8'h01);
    chk("R11 cmd after abort", port_out, 2);
  endtask

  task automatic t_glitch;
    glitch_byte = 0; tx_q[0] = 8'h83; frame(1, 0); glitch_byte = -1;
    chk("R2 glitch rejected", port_out, 3);
  endtask

  initial begin
    repeat (5) @(negedge clk); rst = 0; repeat (3) @(negedge clk);
    t_reset; t_adc_and_state; t_port; t_timing; t_data4; t_data3;
    t_ignore; t_abort; t_glitch;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule